// File: doc/BRIEF.md
# Strap-Latched Configuration Register with Boot Remap Decoder

This block holds one 32-bit configuration word. When reset is released, the low bits of the word are loaded from a bus of hardware strap pins. Each strap pin has a weak pull-up on the board, so a pin nobody drives arrives as 1. After that load, only software writes through the register port can change the word.

The block also decodes three things from that word:
- **Address map.** The top bit selects between two maps. In the boot map, the bottom 256 MB region reaches the expansion bus, so the processor can fetch boot code from flash. Once software clears the bit, the bottom region reaches DRAM and the expansion bus moves to the region starting at 0x50000000.
- **Flash data width.** Two separated bits of the word select the width.
- **Drive strength.** Two separated bits of the word select the strength.

For both two-bit fields, a reserved code raises an error flag and keeps the last valid decoded value.

Address lookups come in on a valid/ready stream and leave on a registered valid/ready stream:
- The input is accepted when `acc_valid_i` and `acc_ready_o` are both high.
- `acc_ready_o` is high whenever the output stage is empty or is being drained in the same cycle.
- While `res_valid_o` is high and `res_ready_i` is low, the result is held unchanged and no new lookup is accepted.

Top module: `cfg_remap_top`

## Requirements
- R1: While reset is asserted, the register reads 0x80000008, so bit 31 (remap) and bit 3 are both 1.
- R2: On the first clock edge after reset is released, bits [9:0] take the strap pins (bit 3 forced to 1), bit 31 is 1 and the other bits are 0. Later strap changes have no effect on the register.
- R3: After any register write, bit 3 reads as 1, whatever value was written to it.
- R4: A write stores `reg_wdata_i` (with bit 3 set). The new value reads back on `reg_rdata_o` from the next cycle.
- R5: With bit 31 = 1, an address whose bits [31:28] are 0 selects the expansion bus. Every other address gives a decode error.
- R6: With bit 31 = 0, bits [31:28] = 0 select DRAM and bits [31:28] = 5 select the expansion bus. Every other address gives a decode error. Exactly one of the three result flags is high with each result.
- R7: A lookup uses the map in force in the cycle it is accepted. A write in that same cycle affects only later lookups.
- R8: A lookup accepted at one edge shows its result after that edge. The result stays stable while `res_ready_i` is low, and during that time `acc_ready_o` is low.
- R9: The flash width code is {bit 7, bit 0}: 00 gives 16-bit (output 1), 01 gives 8-bit (output 0), 11 gives 32-bit (output 2).
- R10: Flash width code 10 is reserved. It raises `flash_err_o`, and `flash_width_o` keeps its last valid value.
- R11: The drive code is {bit 9, bit 5}: 01 gives medium (output 1), 10 gives low (output 0), 11 gives high (output 2). Code 00 raises `drive_err_o`, and `drive_o` keeps its last valid value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 10 | Strap pin levels, pulled up when undriven |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Current register value |
| acc_valid_i | input | 1 | Lookup request valid |
| acc_ready_o | output | 1 | Lookup request accepted when high |
| acc_addr_i | input | 32 | Address to look up |
| res_valid_o | output | 1 | Lookup result valid |
| res_ready_i | input | 1 | Consumer takes the result |
| res_exp_o | output | 1 | Result selects the expansion bus |
| res_dram_o | output | 1 | Result selects DRAM |
| res_decerr_o | output | 1 | Result maps to no target |
| flash_width_o | output | 2 | Decoded flash width (0 = 8-bit, 1 = 16-bit, 2 = 32-bit) |
| flash_err_o | output | 1 | Flash width field holds a reserved code |
| drive_o | output | 2 | Decoded drive strength (0 = low, 1 = medium, 2 = high) |
| drive_err_o | output | 1 | Drive field holds a reserved code |

## Verification
Faults in the register appear at once on `reg_rdata_o`:
- A register that re-captures straps, or never captures them, shows the wrong value one cycle after reset release or after a later strap change.
- A lost bit 3 shows up the cycle after a write.

A wrong remap snapshot can only be seen on the result stream, one edge after acceptance. The directed tests therefore place a write in the same cycle as an accepted lookup and compare the selected target.

A faulty hold register in a field decoder stays hidden until a reserved code is written. The tests write each reserved code right after a known valid code and check the held value.

// File: rtl/cfg_remap_pkg.sv
package cfg_remap_pkg;
  typedef enum logic [1:0] {FW_8 = 2'd0, FW_16 = 2'd1, FW_32 = 2'd2} flash_w_e;
  typedef enum logic [1:0] {DRV_LOW = 2'd0, DRV_MED = 2'd1, DRV_HIGH = 2'd2} drv_e;

  typedef struct packed {
    logic exp;
    logic dram;
    logic decerr;
  } target_t;
endpackage

// File: rtl/cfg_strap_reg.sv
module cfg_strap_reg #(
  parameter int DATA_W  = 32,
  parameter int STRAP_W = 10,
  parameter int REMAP_B = 31,
  parameter int RSV_B   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  word_o
);
  localparam logic [DATA_W-1:0] RSV_MASK = DATA_W'(1) << RSV_B;
  localparam logic [DATA_W-1:0] RST_WORD = (DATA_W'(1) << REMAP_B) | RSV_MASK;

  logic [DATA_W-1:0] word_q;
  logic              captured_q;
  logic [DATA_W-1:0] strap_word;

  assign strap_word = RST_WORD | DATA_W'(strap_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q     <= RST_WORD;
      captured_q <= 1'b0;
    end else if (!captured_q) begin
      word_q     <= strap_word;
      captured_q <= 1'b1;
    end else if (wr_i) begin
      word_q <= wdata_i | RSV_MASK;
    end
  end

  assign word_o = word_q;

  AST_STRAP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (captured_q && !wr_i) |=> $stable(word_q)); // R2
  AST_RSV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (captured_q && wr_i) |=> word_q[RSV_B]); // R3
  AST_BOOT_BEFORE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !captured_q |-> word_q[REMAP_B]); // R1
endmodule

// File: rtl/cfg_pair_decode.sv
module cfg_pair_decode #(
  parameter logic [1:0] VAL0 = 2'd0,
  parameter logic [1:0] VAL1 = 2'd0,
  parameter logic [1:0] VAL2 = 2'd0,
  parameter logic [1:0] VAL3 = 2'd0,
  parameter int         RSVD = 0,
  parameter logic [1:0] INIT = 2'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code_i,
  output logic [1:0] value_o,
  output logic       err_o
);
  localparam logic [1:0] LUT [4] = '{VAL0, VAL1, VAL2, VAL3};

  logic [1:0] held_q;
  logic [1:0] fresh;

  assign fresh   = LUT[code_i];
  assign err_o   = (code_i == 2'(RSVD));
  assign value_o = err_o ? held_q : fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= INIT;
    else        held_q <= value_o;
  end

  AST_HOLD_ON_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $stable(value_o)); // R10
endmodule

// File: rtl/cfg_addr_map.sv
module cfg_addr_map
  import cfg_remap_pkg::*;
#(
  parameter int         ADDR_W   = 32,
  parameter int         REGION_W = 4,
  parameter logic [3:0] BOOT_RGN = 4'h0,
  parameter logic [3:0] EXP_RGN  = 4'h5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              remap_i,
  input  logic              acc_valid_i,
  output logic              acc_ready_o,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output target_t           res_o
);
  localparam int RGN_LSB = ADDR_W - REGION_W;

  logic [REGION_W-1:0] region;
  target_t             next_tgt;
  target_t             tgt_q;
  logic                valid_q;

  assign region = acc_addr_i[ADDR_W-1:RGN_LSB];

  always_comb begin
    next_tgt = '{exp: 1'b0, dram: 1'b0, decerr: 1'b1};
    if (remap_i) begin
      if (region == REGION_W'(BOOT_RGN)) next_tgt = '{exp: 1'b1, dram: 1'b0, decerr: 1'b0};
    end else begin
      if (region == REGION_W'(BOOT_RGN))     next_tgt = '{exp: 1'b0, dram: 1'b1, decerr: 1'b0};
      else if (region == REGION_W'(EXP_RGN)) next_tgt = '{exp: 1'b1, dram: 1'b0, decerr: 1'b0};
    end
  end

  assign acc_ready_o = !valid_q || res_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tgt_q   <= '0;
    end else if (acc_ready_o) begin
      valid_q <= acc_valid_i;
      if (acc_valid_i) tgt_q <= next_tgt;
    end
  end

  assign res_valid_o = valid_q;
  assign res_o       = tgt_q;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $onehot({res_o.exp, res_o.dram, res_o.decerr})); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_o))); // R8
  AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |-> !acc_ready_o); // R8
endmodule

// File: rtl/cfg_remap_top.sv
module cfg_remap_top
  import cfg_remap_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STRAP_W  = 10,
  parameter int REMAP_B  = 31,
  parameter int RSV_B    = 3,
  parameter int FW_HI_B  = 7,
  parameter int FW_LO_B  = 0,
  parameter int DRV_HI_B = 9,
  parameter int DRV_LO_B = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               reg_wr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               acc_valid_i,
  output logic               acc_ready_o,
  input  logic [DATA_W-1:0]  acc_addr_i,
  output logic               res_valid_o,
  input  logic               res_ready_i,
  output logic               res_exp_o,
  output logic               res_dram_o,
  output logic               res_decerr_o,
  output logic [1:0]         flash_width_o,
  output logic               flash_err_o,
  output logic [1:0]         drive_o,
  output logic               drive_err_o
);
  logic [DATA_W-1:0] word;
  target_t           res;

  cfg_strap_reg #(
    .DATA_W(DATA_W), .STRAP_W(STRAP_W), .REMAP_B(REMAP_B), .RSV_B(RSV_B)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
    .wr_i(reg_wr_i), .wdata_i(reg_wdata_i), .word_o(word)
  );

  assign reg_rdata_o = word;

  cfg_addr_map #(.ADDR_W(DATA_W)) u_map (
    .clk(clk), .rst_n(rst_n), .remap_i(word[REMAP_B]),
    .acc_valid_i(acc_valid_i), .acc_ready_o(acc_ready_o), .acc_addr_i(acc_addr_i),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready_i), .res_o(res)
  );

  assign res_exp_o    = res.exp;
  assign res_dram_o   = res.dram;
  assign res_decerr_o = res.decerr;

  // width code {hi,lo}: 00 -> 16, 01 -> 8, 10 reserved, 11 -> 32
  cfg_pair_decode #(
    .VAL0(FW_16), .VAL1(FW_8), .VAL2(FW_16), .VAL3(FW_32), .RSVD(2), .INIT(FW_16)
  ) u_fw (
    .clk(clk), .rst_n(rst_n), .code_i({word[FW_HI_B], word[FW_LO_B]}),
    .value_o(flash_width_o), .err_o(flash_err_o)
  );

  // drive code {hi,lo}: 00 reserved, 01 -> medium, 10 -> low, 11 -> high
  cfg_pair_decode #(
    .VAL0(DRV_MED), .VAL1(DRV_MED), .VAL2(DRV_LOW), .VAL3(DRV_HIGH), .RSVD(0), .INIT(DRV_MED)
  ) u_drv (
    .clk(clk), .rst_n(rst_n), .code_i({word[DRV_HI_B], word[DRV_LO_B]}),
    .value_o(drive_o), .err_o(drive_err_o)
  );
endmodule

// File: tb/cfg_remap_top_tb.sv
module cfg_remap_top_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  strap;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        av = 1'b0;
  logic        ardy;
  logic [31:0] addr = '0;
  logic        rv;
  logic        rrdy = 1'b1;
  logic        rexp, rdram, rerr;
  logic [1:0]  fw, drv;
  logic        fwerr, drverr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_remap_top dut_i (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .acc_valid_i(av), .acc_ready_o(ardy), .acc_addr_i(addr),
    .res_valid_o(rv), .res_ready_i(rrdy), .res_exp_o(rexp), .res_dram_o(rdram),
    .res_decerr_o(rerr), .flash_width_o(fw), .flash_err_o(fwerr),
    .drive_o(drv), .drive_err_o(drverr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [31:0] v);
    @(negedge clk); wr = 1'b1; wdata = v;
    @(negedge clk); wr = 1'b0;
  endtask

  // one lookup; result sampled at the negedge after acceptance
  task automatic lookup(input string req, input logic [31:0] a, input logic [2:0] exp_tgt);
    @(negedge clk); av = 1'b1; addr = a;
    @(negedge clk); av = 1'b0;
    chk(req, {28'd0, rv, rexp, rdram, rerr}, {28'd0, 1'b1, exp_tgt});
  endtask

  task automatic t_reset_and_strap();
    strap = 10'h2A5;
    #(CLK_PERIOD*2);
    chk("R1 reset word", rdata, 32'h8000_0008);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2 strap capture", rdata, 32'h8000_02AD);
    chk("R9 width from straps 32", {30'd0, fw}, 32'd2);
    chk("R11 drive from straps high", {30'd0, drv}, 32'd2);
    strap = 10'h000;
    repeat (3) @(negedge clk);
    chk("R2 later strap ignored", rdata, 32'h8000_02AD);
  endtask

  task automatic t_boot_map();
    lookup("R5 boot region exp", 32'h0123_4567, 3'b100);
    lookup("R5 high window decerr", 32'h5000_0000, 3'b001);
    lookup("R5 region1 decerr", 32'h1000_0000, 3'b001);
  endtask

  task automatic t_write_rsv();
    write_reg(32'h0000_0000);
    chk("R3 R4 readback rsv bit", rdata, 32'h0000_0008);
    chk("R9 width 16", {30'd0, fw}, 32'd1);
    chk("R11 drive reserved flag", {31'd0, drverr}, 32'd1);
    chk("R11 drive held high", {30'd0, drv}, 32'd2);
  endtask

  task automatic t_run_map();
    lookup("R6 dram low", 32'h0FFF_FFFC, 3'b010);
    lookup("R6 exp window", 32'h5ABC_0000, 3'b100);
    lookup("R6 exp window top", 32'h5FFF_FFFF, 3'b100);
    lookup("R6 above window", 32'h6000_0000, 3'b001);
    lookup("R6 below window", 32'h4FFF_FFFF, 3'b001);
  endtask

  task automatic t_width();
    write_reg(32'h0000_0081);
    chk("R9 width 32", {30'd0, fw}, 32'd2);
    write_reg(32'h0000_0001);
    chk("R9 width 8", {30'd0, fw}, 32'd0);
    chk("R10 no flag on valid", {31'd0, fwerr}, 32'd0);
    write_reg(32'h0000_0080);
    chk("R10 reserved flag", {31'd0, fwerr}, 32'd1);
    chk("R10 width held 8", {30'd0, fw}, 32'd0);
    chk("R4 readback", rdata, 32'h0000_0088);
  endtask

  task automatic t_drive();
    write_reg(32'h0000_0200);
    chk("R11 drive low", {30'd0, drv}, 32'd0);
    write_reg(32'h0000_0220);
    chk("R11 drive high", {30'd0, drv}, 32'd2);
    write_reg(32'h0000_0020);
    chk("R11 drive medium", {30'd0, drv}, 32'd1);
    write_reg(32'h0000_0000);
    chk("R11 reserved held medium", {30'd0, drv}, 32'd1);
    chk("R11 reserved flag", {31'd0, drverr}, 32'd1);
  endtask

  task automatic t_snapshot();
    @(negedge clk); av = 1'b1; addr = 32'h0000_0100; wr = 1'b1; wdata = 32'h8000_0000;
    @(negedge clk); av = 1'b0; wr = 1'b0;
    chk("R7 old map used", {29'd0, rexp, rdram, rerr}, 32'b010);
    lookup("R7 new map next", 32'h0000_0100, 3'b100);
    write_reg(32'h0000_0000);
  endtask

  task automatic t_backpressure();
    @(negedge clk); rrdy = 1'b0; av = 1'b1; addr = 32'h0000_0040;
    @(negedge clk); addr = 32'h6000_0000;
    chk("R8 result valid", {31'd0, rv}, 32'd1);
    chk("R8 ready low in stall", {31'd0, ardy}, 32'd0);
    @(negedge clk);
    chk("R8 held result", {29'd0, rexp, rdram, rerr}, 32'b010);
    rrdy = 1'b1;
    @(negedge clk); av = 1'b0;
    chk("R8 next result after drain", {28'd0, rv, rexp, rdram, rerr}, 32'b1001);
    @(negedge clk);
    chk("R8 empty after drain", {31'd0, rv}, 32'd0);
  endtask

  initial begin
    t_reset_and_strap();
    t_boot_map();
    t_write_rsv();
    t_run_map();
    t_width();
    t_drive();
    t_snapshot();
    t_backpressure();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule